// File: doc/BRIEF.md
# Byte Add/Subtract Unit with Condition Flags

This block is the arithmetic slice of a small processor datapath. Each cycle it may accept two byte operands, an operation code and a carry input, qualified by a valid strobe. It performs add, add-with-carry, subtract, subtract-with-borrow or compare. One clock later it presents a registered result and a registered set of six condition flags. The flags are derived from the operands, the result and the kind of operation. For example, the carry flag reads as a borrow after any subtracting operation.

A trap output lets software avoid testing for overflow after every instruction. When the caller sets the trap enable alongside an operation that overflows in the signed sense, the block raises a one-cycle trap request with a fixed handler code. Compare runs the subtract path purely to set the flags and leaves the stored result alone. Codes outside the five defined operations are ignored.

Top module: `byte_alu`

## Requirements
- R1: Opcode 0 (add) produces (A + B) mod 256 and opcode 1 (add with carry) produces (A + B + carry_in) mod 256. Flag bit 0 (carry) is 1 exactly when the true unsigned sum exceeds 255. For example, 255 + 7 gives 6 with carry set.
- R2: Opcode 2 (subtract) produces (A − B) mod 256 and opcode 3 (subtract with borrow) produces (A − B − carry_in) mod 256. Flag bit 0 is 1 exactly when the true difference is negative (a borrow). For example, 1 − 5 gives 252 with bit 0 set, and 200 − 100 leaves bit 0 clear.
- R3: Flag bit 5 (overflow) is 1 exactly when the true signed result, treating operands as two's complement, lies outside −128..127. For example, 100 + 50 sets it.
- R4: Flag bit 2 (auxiliary) is 1 on a carry out of the low 4-bit nibble for additions, and on a borrow into it for subtractions.
- R5: Flag bit 1 (parity) is 1 when the 8-bit result holds an even number of one bits, and 0 when the count is odd.
- R6: Flag bit 3 (zero) is 1 exactly when the 8-bit result is zero. Flag bit 4 (sign) equals result bit 7.
- R7: Opcode 4 (compare) updates all flags as for opcode 2 but leaves `result` unchanged.
- R8: Result and flags appear one clock after the valid cycle. They hold their values in every cycle where `in_valid` is low.
- R9: Consider a valid, defined operation with `trap_en` high that sets the overflow flag. In the following cycle, `trap_req` is 1 for exactly one clock and `trap_code` is 4. In every other cycle, `trap_req` is 0 and `trap_code` is 0. A carry never causes a trap.
- R10: A synchronous active-high `rst` clears result, flags, `trap_req` and `trap_code` to zero on the next clock.
- R11: Opcodes 5, 6 and 7 are ignored even with `in_valid` high: result and flags keep their values and no trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 3 | Operation code (0 add, 1 add-carry, 2 sub, 3 sub-borrow, 4 compare) |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| carry_in | input | 1 | Carry or borrow input for opcodes 1 and 3 |
| trap_en | input | 1 | Request a trap if this operation overflows |
| result | output | 8 | Registered result |
| flags | output | 6 | Registered flags {overflow, sign, zero, aux, parity, carry} |
| trap_req | output | 1 | One-cycle trap request |
| trap_code | output | 8 | Handler number (4) while trap_req is high, else 0 |

## Verification
Every result, flag and trap output is due exactly one clock edge after the cycle that carried the operation, because each passes through a single register stage. The bench drives each operation just after a falling edge and samples two time units after the next rising edge. That sample point is the first instant the new values exist and the last before the next operation lands. Hold, compare and ignored-opcode checks use the same sample point. There, the bench compares against the value it expected before the stimulus, which confirms that nothing moved during the cycle in question.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_CMP = 3'd4
  } alu_op_e;

  // Packed MSB first: ovf is bit 5, cy is bit 0.
  typedef struct packed {
    logic ovf;
    logic sign;
    logic zero;
    logic aux;
    logic par;
    logic cy;
  } flags_t;

  localparam int FLAG_W = $bits(flags_t);

endpackage

// File: rtl/byte_alu_opdecode.sv
module byte_alu_opdecode
  import byte_alu_pkg::*;
(
  input  logic [2:0] op_code,
  output logic       is_sub,
  output logic       use_cin,
  output logic       wr_res,
  output logic       legal
);

  always_comb begin
    is_sub  = 1'b0;
    use_cin = 1'b0;
    wr_res  = 1'b0;
    legal   = 1'b1;
    case (alu_op_e'(op_code))
      OP_ADD: begin wr_res = 1'b1; end
      OP_ADC: begin wr_res = 1'b1; use_cin = 1'b1; end
      OP_SUB: begin wr_res = 1'b1; is_sub = 1'b1; end
      OP_SBB: begin wr_res = 1'b1; is_sub = 1'b1; use_cin = 1'b1; end
      OP_CMP: begin is_sub = 1'b1; end
      default: begin legal = 1'b0; end
    endcase
  end

endmodule

// File: rtl/byte_alu_addsub.sv
module byte_alu_addsub #(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         is_sub,
  input  logic         use_cin,
  output logic [W-1:0] res,
  output logic         cy,
  output logic         aux,
  output logic         ovf
);

  logic [W-1:0] b_eff;
  logic         c_eff;
  logic [W:0]   full;
  logic [NIB:0] low;

  // Subtraction as a + ~b + (1 - borrow_in); carry out inverted gives the borrow.
  always_comb begin
    b_eff = is_sub ? ~b : b;
    c_eff = is_sub ^ (use_cin & cin);
    full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    low   = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c_eff};
    res   = full[W-1:0];
    cy    = full[W] ^ is_sub;
    aux   = low[NIB] ^ is_sub;
    ovf   = (a[W-1] == b_eff[W-1]) && (res[W-1] != a[W-1]);
  end

endmodule

// File: rtl/byte_alu_flaggen.sv
module byte_alu_flaggen
  import byte_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] res,
  input  logic         cy,
  input  logic         aux,
  input  logic         ovf,
  output flags_t       fl
);

  always_comb begin
    fl.ovf  = ovf;
    fl.sign = res[W-1];
    fl.zero = (res == '0);
    fl.aux  = aux;
    fl.par  = ~^res;
    fl.cy   = cy;
  end

endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NIBBLE_W = 4,
  parameter int TRAP_W   = 8,
  parameter int TRAP_ID  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              carry_in,
  input  logic              trap_en,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags,
  output logic              trap_req,
  output logic [TRAP_W-1:0] trap_code
);

  localparam logic [TRAP_W-1:0] TRAP_VAL = TRAP_W'(TRAP_ID);

  logic              is_sub, use_cin, wr_res, legal;
  logic [DATA_W-1:0] res_n;
  logic              cy_n, aux_n, ovf_n;
  flags_t            fl_n;

  logic [DATA_W-1:0] result_q;
  flags_t            flags_q;
  logic              trap_q;
  logic [TRAP_W-1:0] code_q;

  byte_alu_opdecode u_dec (
    .op_code (op),
    .is_sub  (is_sub),
    .use_cin (use_cin),
    .wr_res  (wr_res),
    .legal   (legal)
  );

  byte_alu_addsub #(.W(DATA_W), .NIB(NIBBLE_W)) u_addsub (
    .a       (opnd_a),
    .b       (opnd_b),
    .cin     (carry_in),
    .is_sub  (is_sub),
    .use_cin (use_cin),
    .res     (res_n),
    .cy      (cy_n),
    .aux     (aux_n),
    .ovf     (ovf_n)
  );

  byte_alu_flaggen #(.W(DATA_W)) u_flags (
    .res (res_n),
    .cy  (cy_n),
    .aux (aux_n),
    .ovf (ovf_n),
    .fl  (fl_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      flags_q  <= '0;
      trap_q   <= 1'b0;
      code_q   <= '0;
    end else begin
      trap_q <= 1'b0;
      code_q <= '0;
      if (in_valid && legal) begin
        flags_q <= fl_n;
        if (wr_res) result_q <= res_n;
        if (trap_en && ovf_n) begin
          trap_q <= 1'b1;
          code_q <= TRAP_VAL;
        end
      end
    end
  end

  assign result    = result_q;
  assign flags     = flags_q;
  assign trap_req  = trap_q;
  assign trap_code = code_q;

  // R1: an unsigned wrap on plain add leaves a sum below the first operand
  a_r1_add_wrap: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legal && !is_sub && !use_cin) |-> (cy_n == (res_n < opnd_a)));

  // R2: a plain subtract borrows exactly when A < B
  a_r2_sub_borrow: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legal && is_sub && !use_cin) |-> (cy_n == (opnd_a < opnd_b)));

  // R7: compare keeps the stored result
  a_r7_cmp_keeps: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd4) |=> $stable(result));

  // R8: idle cycles hold result and flags
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(flags)));

  // R9: a trap always accompanies a stored overflow flag and a requested enable
  a_r9_trap_cause: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (flags[FLAG_W-1] && $past(trap_en)));

  // R9: the handler code is present exactly while the trap is raised
  a_r9_trap_code: assert property (@(posedge clk) disable iff (rst)
    trap_req == (trap_code == TRAP_VAL));

  // R10: reset clears every output
  a_r10_reset: assert property (@(posedge clk)
    rst |=> (result == '0 && flags == '0 && !trap_req && trap_code == '0));

  // R11: undefined codes change nothing
  a_r11_ignored: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op > 3'd4) |=> ($stable(result) && $stable(flags) && !trap_req));

endmodule

// File: tb/test_byte_alu.sv
module test_byte_alu;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [2:0] op = 3'd0;
  logic [7:0] opnd_a = 8'd0;
  logic [7:0] opnd_b = 8'd0;
  logic       carry_in = 1'b0;
  logic       trap_en = 1'b0;
  logic [7:0] result;
  logic [5:0] flags;
  logic       trap_req;
  logic [7:0] trap_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] exp_res   = 8'd0;
  logic [5:0] exp_flags = 6'd0;
  logic       exp_trap  = 1'b0;

  always #5 clk = ~clk;

  byte_alu i_byte_alu (
    .clk, .rst, .in_valid, .op, .opnd_a, .opnd_b, .carry_in, .trap_en,
    .result, .flags, .trap_req, .trap_code
  );

  task automatic compare_outputs(input string tag);
    logic [7:0] exp_code;
    exp_code = exp_trap ? 8'd4 : 8'd0;
    checks++;
    if (result !== exp_res || flags !== exp_flags || trap_req !== exp_trap
        || trap_code !== exp_code) begin
      fails++;
      $display("FAIL %s: got res=%0d flags=%b trap=%b code=%0d, expected res=%0d flags=%b trap=%b code=%0d",
               tag, result, flags, trap_req, trap_code, exp_res, exp_flags, exp_trap, exp_code);
    end
  endtask

  // Expected value from integer arithmetic on the requirements.
  task automatic model(input logic [2:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic c, input logic te);
    int ua, ub, sa, sb, ci, t, st, nib;
    logic [7:0] er;
    logic ecy, eaux, eov;
    ua = a; ub = b;
    sa = (a > 8'd127) ? ua - 256 : ua;
    sb = (b > 8'd127) ? ub - 256 : ub;
    ci = (o == 3'd1 || o == 3'd3) ? int'(c) : 0;
    if (o <= 3'd1) begin
      t = ua + ub + ci; ecy = (t > 255);
      nib = (ua % 16) + (ub % 16) + ci; eaux = (nib > 15);
      st = sa + sb + ci;
    end else begin
      t = ua - ub - ci; ecy = (t < 0);
      nib = (ua % 16) - (ub % 16) - ci; eaux = (nib < 0);
      st = sa - sb - ci;
    end
    er  = t[7:0];
    eov = (st > 127) || (st < -128);
    exp_trap = 1'b0;
    if (o <= 3'd4) begin
      exp_flags = {eov, er[7], (er == 8'd0), eaux, ($countones(er) % 2 == 0), ecy};
      if (o != 3'd4) exp_res = er;
      exp_trap = te && eov;
    end
  endtask

  task automatic run_op(input logic [2:0] o, input logic [7:0] a, input logic [7:0] b,
                        input logic c, input logic te, input string tag);
    @(negedge clk);
    in_valid = 1'b1; op = o; opnd_a = a; opnd_b = b; carry_in = c; trap_en = te;
    @(posedge clk);
    #2;
    model(o, a, b, c, te);
    compare_outputs(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    in_valid = 1'b0; op = 3'd0; opnd_a = 8'd99; opnd_b = 8'd1; trap_en = 1'b1;
    @(posedge clk);
    #2;
    exp_trap = 1'b0;
    compare_outputs(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    compare_outputs("R10 reset state");
    @(negedge clk); rst = 1'b0;

    // Worked examples
    run_op(3'd0, 8'd255, 8'd7,   1'b0, 1'b0, "R1 255+7");
    run_op(3'd0, 8'd255, 8'd1,   1'b0, 1'b0, "R1 R6 255+1 zero");
    run_op(3'd1, 8'd15,  8'd0,   1'b1, 1'b0, "R1 R4 adc nibble carry");
    run_op(3'd2, 8'd1,   8'd5,   1'b0, 1'b0, "R2 1-5");
    run_op(3'd2, 8'd200, 8'd100, 1'b0, 1'b0, "R2 200-100");
    run_op(3'd3, 8'd100, 8'd56,  1'b1, 1'b0, "R2 sbb borrow in");
    run_op(3'd0, 8'd100, 8'd50,  1'b0, 1'b1, "R3 R9 100+50 trap");
    run_op(3'd0, 8'd1,   8'd2,   1'b0, 1'b1, "R9 trap drops");
    run_op(3'd0, 8'd100, 8'd50,  1'b0, 1'b0, "R9 no trap when disabled");
    run_op(3'd0, 8'd255, 8'd255, 1'b0, 1'b1, "R9 carry never traps");
    run_op(3'd2, 8'd128, 8'd1,   1'b0, 1'b1, "R3 R9 sub overflow trap");
    run_op(3'd4, 8'd7,   8'd7,   1'b0, 1'b0, "R7 compare equal");
    run_op(3'd4, 8'd3,   8'd9,   1'b0, 1'b1, "R7 compare less");
    run_op(3'd5, 8'd127, 8'd1,   1'b0, 1'b1, "R11 opcode 5");
    run_op(3'd7, 8'd0,   8'd0,   1'b1, 1'b1, "R11 opcode 7");
    idle("R8 hold");
    idle("R8 hold second");

    // Sync reset mid-run
    run_op(3'd0, 8'd200, 8'd100, 1'b0, 1'b0, "R1 before reset");
    @(negedge clk); rst = 1'b1; in_valid = 1'b1;
    @(posedge clk); #2;
    exp_res = 8'd0; exp_flags = 6'd0; exp_trap = 1'b0;
    compare_outputs("R10 mid-run reset");
    @(negedge clk); rst = 1'b0; in_valid = 1'b0;

    // Exhaustive sweeps of add and subtract
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        run_op(3'd0, 8'(a), 8'(b), 1'b0, a[2], "R1 R3 R4 R5 R6 R9 add sweep");
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        run_op(3'd2, 8'(a), 8'(b), 1'b0, b[2], "R2 R3 R4 R5 R6 R9 sub sweep");
    // Strided sweeps of carry-using ops and compare
    for (int o = 1; o <= 4; o++) begin
      if (o == 2) continue;
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b += 7)
          run_op(3'(o), 8'(a), 8'(b), a[0] ^ b[0], a[1], "R1 R2 R7 R8 carry/compare sweep");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule